// File: doc/BRIEF.md
# Memory Mode Register Capture and Command Legality Checker

This block sits beside a mobile DDR memory controller. It watches the decoded command stream and keeps a shadow copy of the memory's mode register: CAS latency, burst type and burst length. Software and the sequencer read the decoded settings from its outputs instead of re-parsing the address bus.

The block only accepts a mode-register write under the right conditions. All banks must be idle, the command must target bank address zero, and every field encoding must be legal. After an accepted write it raises `busy` for a fixed number of cycles. Any real command issued in that window is flagged. Later reads and writes are checked against the programmed burst length: auto precharge is illegal with full-page bursts.

Each illegal action sets its own sticky error flag. The flags clear only on reset.

Top module: `mrchk_top`

## Requirements
- R1: After synchronous reset the outputs show CAS latency 2, sequential burst type (`burst_interleaved`=0), burst length 2, `burst_full_page`=0, `busy`=0 and all four error flags cleared.
- R2: A command is live when `cmd_valid`=1 and `cmd_type` is not 0 (no-op). A live `cmd_type`=1 (mode-register set) with `bank_addr`=0, all banks idle and legal fields updates the outputs on the next clock edge. Burst length comes from `addr[2:0]`: 001→2, 010→4, 011→8, 100→16, and 111→full page, reported as `burst_len`=0 with `burst_full_page`=1. Burst type comes from `addr[3]` (1 = interleaved). CAS latency comes from `addr[6:4]`: 010→2, 011→3.
- R3: A mode-register set with a non-zero `bank_addr` leaves the settings unchanged. It sets no error and does not raise `busy`.
- R4: A mode-register set is rejected if it carries a reserved burst-length code, a reserved CAS-latency code, or full page with interleaved type. The settings stay unchanged and `err_reserved` is set.
- R5: A mode-register set to bank address 0 while any `bank_idle` bit is 0 sets `err_not_idle` and leaves the settings unchanged. This check takes priority over R4.
- R6: After an accepted mode-register set, `busy` is 1 for exactly `WAIT_CYC` cycles (default 2), starting the cycle after the command.
- R7: Any live command while `busy`=1 sets `err_holdoff` and is otherwise ignored. A mode-register set in that window does not change the settings. A no-op while `busy`=1 sets nothing.
- R8: When full page is programmed, a live read (`cmd_type`=3) or write (`cmd_type`=4) with the auto-precharge bit `addr[AP_BIT]` (default bit 10) set raises `err_fullpage_ap`. With any other burst length, or with that bit clear, no error is raised.
- R9: Error flags stay set until reset, even across later legal commands. Stored settings persist until the next accepted mode-register set or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_type | input | 3 | Decoded command: 0 no-op, 1 mode set, 2 activate, 3 read, 4 write, 5 precharge, 6 refresh, 7 other |
| bank_addr | input | BA_W (2) | Bank address of the command |
| addr | input | ADDR_W (13) | Row/column address bus |
| bank_idle | input | BANKS (4) | Per-bank idle status |
| cas_latency | output | 2 | Programmed CAS latency (2 or 3) |
| burst_interleaved | output | 1 | 1 = interleaved burst order |
| burst_len | output | 5 | Burst length, 0 when full page |
| burst_full_page | output | 1 | Full-page burst programmed |
| busy | output | 1 | Post-programming hold-off active |
| err_not_idle | output | 1 | Sticky: mode set with a bank open |
| err_reserved | output | 1 | Sticky: reserved encoding rejected |
| err_holdoff | output | 1 | Sticky: command during hold-off |
| err_fullpage_ap | output | 1 | Sticky: auto precharge with full page |

## Verification
The bench checks the hold-off window edge by edge: `busy` must drop on exactly the third sampled cycle. A command in the last busy cycle must still be caught, which exposes an off-by-one counter. It sends a mode set with a non-zero bank address and a mode set during hold-off. A design that let either one through would show changed settings at the ports. It covers each reserved code, including full page combined with interleaved, which a decoder checking fields one at a time would accept. It also issues reads and writes with auto precharge under both full-page and 8-beat bursts, so a checker that ignored the stored burst length would flag the wrong case.

// File: rtl/mrchk_pkg.sv
package mrchk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_MRS   = 3'd1,
        CMD_ACT   = 3'd2,
        CMD_RD    = 3'd3,
        CMD_WR    = 3'd4,
        CMD_PRE   = 3'd5,
        CMD_REF   = 3'd6,
        CMD_OTHER = 3'd7
    } cmd_e;

    typedef struct packed {
        logic [2:0] cl_code;
        logic       interleaved;
        logic [2:0] bl_code;
    } mode_t;

    typedef struct packed {
        logic not_idle;
        logic reserved;
        logic holdoff;
        logic fullpage_ap;
    } err_t;

    localparam int MODE_W = $bits(mode_t);
    localparam int ERR_N  = $bits(err_t);

    localparam mode_t MODE_RESET = '{cl_code: 3'b010, interleaved: 1'b0, bl_code: 3'b001};

    function automatic logic cl_legal(input logic [2:0] c);
        return (c == 3'b010) || (c == 3'b011);
    endfunction

    function automatic logic bl_full(input logic [2:0] b);
        return b == 3'b111;
    endfunction

    function automatic logic bl_legal(input logic [2:0] b);
        return (b inside {3'b001, 3'b010, 3'b011, 3'b100}) || bl_full(b);
    endfunction

    function automatic logic [1:0] cl_value(input logic [2:0] c);
        return c[0] ? 2'd3 : 2'd2;
    endfunction

    function automatic logic [4:0] bl_value(input logic [2:0] b);
        case (b)
            3'b001:  return 5'd2;
            3'b010:  return 5'd4;
            3'b011:  return 5'd8;
            3'b100:  return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/mrchk_decode.sv
module mrchk_decode
    import mrchk_pkg::*;
(
    input  logic [MODE_W-1:0] field_bits,
    output mode_t             cand,
    output logic              legal
);
    always_comb begin
        cand  = mode_t'(field_bits);
        legal = cl_legal(cand.cl_code) && bl_legal(cand.bl_code)
                && !(bl_full(cand.bl_code) && cand.interleaved);
    end
endmodule

// File: rtl/mrchk_holdoff.sv
module mrchk_holdoff #(
    parameter int WAIT_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    generate
        if (WAIT_CYC == 0) begin : g_none
            assign busy = 1'b0;
        end else begin : g_count
            localparam int CW = $clog2(WAIT_CYC + 1);
            localparam logic [CW-1:0] LOAD = CW'(WAIT_CYC);
            logic [CW-1:0] remain;

            always_ff @(posedge clk) begin
                if (rst)
                    remain <= '0;
                else if (start)
                    remain <= LOAD;
                else if (remain != '0)
                    remain <= remain - 1'b1;
            end

            assign busy = (remain != '0);

            assert_busy_start_R6: assert property (@(posedge clk) disable iff (rst)
                start |=> busy);
            assert_busy_idle_R6: assert property (@(posedge clk) disable iff (rst)
                (!busy && !start) |=> !busy);
        end
    endgenerate
endmodule

// File: rtl/mrchk_errors.sv
module mrchk_errors
    import mrchk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  err_t set,
    output err_t flags
);
    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= flags | set;
    end

    generate
        for (genvar i = 0; i < ERR_N; i++) begin : g_chk
            assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
                flags[i] |=> flags[i]);
            assert_set_R9: assert property (@(posedge clk) disable iff (rst)
                set[i] |=> flags[i]);
        end
    endgenerate
endmodule

// File: rtl/mrchk_top.sv
module mrchk_top
    import mrchk_pkg::*;
#(
    parameter int BANKS    = 4,
    parameter int BA_W     = 2,
    parameter int ADDR_W   = 13,
    parameter int AP_BIT   = 10,
    parameter int WAIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_type,
    input  logic [BA_W-1:0]   bank_addr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANKS-1:0]  bank_idle,
    output logic [1:0]        cas_latency,
    output logic              burst_interleaved,
    output logic [4:0]        burst_len,
    output logic              burst_full_page,
    output logic              busy,
    output logic              err_not_idle,
    output logic              err_reserved,
    output logic              err_holdoff,
    output logic              err_fullpage_ap
);
    cmd_e  cmd;
    mode_t mode_q;
    mode_t cand;
    logic  legal;
    logic  live, mrs_any, mrs_bank0, all_idle, mrs_ok, rw_cmd;
    err_t  err_set, err_flags;

    assign cmd       = cmd_e'(cmd_type);
    assign live      = cmd_valid && (cmd != CMD_NOP);
    assign mrs_any   = live && (cmd == CMD_MRS);
    assign mrs_bank0 = mrs_any && (bank_addr == '0);
    assign all_idle  = &bank_idle;
    assign rw_cmd    = live && ((cmd == CMD_RD) || (cmd == CMD_WR));
    assign mrs_ok    = mrs_bank0 && !busy && all_idle && legal;

    mrchk_decode u_decode (
        .field_bits(addr[MODE_W-1:0]),
        .cand      (cand),
        .legal     (legal)
    );

    always_comb begin
        err_set.holdoff     = live && busy;
        err_set.not_idle    = mrs_bank0 && !busy && !all_idle;
        err_set.reserved    = mrs_bank0 && !busy && all_idle && !legal;
        err_set.fullpage_ap = rw_cmd && !busy && addr[AP_BIT] && bl_full(mode_q.bl_code);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_RESET;
        else if (mrs_ok)
            mode_q <= cand;
    end

    mrchk_holdoff #(.WAIT_CYC(WAIT_CYC)) u_holdoff (
        .clk  (clk),
        .rst  (rst),
        .start(mrs_ok),
        .busy (busy)
    );

    mrchk_errors u_errors (
        .clk  (clk),
        .rst  (rst),
        .set  (err_set),
        .flags(err_flags)
    );

    assign cas_latency       = cl_value(mode_q.cl_code);
    assign burst_interleaved = mode_q.interleaved;
    assign burst_len         = bl_value(mode_q.bl_code);
    assign burst_full_page   = bl_full(mode_q.bl_code);
    assign err_not_idle      = err_flags.not_idle;
    assign err_reserved      = err_flags.reserved;
    assign err_holdoff       = err_flags.holdoff;
    assign err_fullpage_ap   = err_flags.fullpage_ap;

    assert_legal_out_R2: assert property (@(posedge clk) disable iff (rst)
        (cas_latency inside {2'd2, 2'd3}) && !(burst_full_page && burst_interleaved));
    assert_bank_filter_R3: assert property (@(posedge clk) disable iff (rst)
        (mrs_any && bank_addr != '0) |=> $stable(mode_q));
    assert_reserved_R4: assert property (@(posedge clk) disable iff (rst)
        (mrs_bank0 && !busy && all_idle && !legal) |=> ($stable(mode_q) && err_reserved));
    assert_not_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (mrs_bank0 && !busy && !all_idle) |=> ($stable(mode_q) && err_not_idle));
    assert_holdoff_R7: assert property (@(posedge clk) disable iff (rst)
        (live && busy) |=> ($stable(mode_q) && err_holdoff));
    assert_fullpage_ap_R8: assert property (@(posedge clk) disable iff (rst)
        (rw_cmd && !busy && addr[AP_BIT] && burst_full_page) |=> err_fullpage_ap);
endmodule

// File: tb/mrchk_top_test.sv
module mrchk_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_type;
    logic [1:0]  bank_addr;
    logic [12:0] addr;
    logic [3:0]  bank_idle;
    logic [1:0]  cas_latency;
    logic        burst_interleaved;
    logic [4:0]  burst_len;
    logic        burst_full_page;
    logic        busy;
    logic        err_not_idle, err_reserved, err_holdoff, err_fullpage_ap;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    mrchk_top uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .bank_addr(bank_addr), .addr(addr), .bank_idle(bank_idle),
        .cas_latency(cas_latency), .burst_interleaved(burst_interleaved),
        .burst_len(burst_len), .burst_full_page(burst_full_page), .busy(busy),
        .err_not_idle(err_not_idle), .err_reserved(err_reserved),
        .err_holdoff(err_holdoff), .err_fullpage_ap(err_fullpage_ap)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [12:0] mr(input logic [2:0] cl, input logic bt, input logic [2:0] bl);
        return {6'd0, cl, bt, bl};
    endfunction

    task automatic chk_mode(input string req, input int cl, input int bt, input int bl, input int fp);
        chk({req, " cl"}, cas_latency, cl);
        chk({req, " bt"}, burst_interleaved, bt);
        chk({req, " bl"}, burst_len, bl);
        chk({req, " fp"}, burst_full_page, fp);
    endtask

    task automatic chk_errs(input string req, input int ni, input int rs, input int ho, input int ap);
        chk({req, " err_not_idle"}, err_not_idle, ni);
        chk({req, " err_reserved"}, err_reserved, rs);
        chk({req, " err_holdoff"}, err_holdoff, ho);
        chk({req, " err_fullpage_ap"}, err_fullpage_ap, ap);
    endtask

    // Called at a falling edge; drives one command, returns at the next falling edge.
    task automatic issue(input logic [2:0] ct, input logic [1:0] ba, input logic [12:0] a);
        cmd_valid = 1'b1; cmd_type = ct; bank_addr = ba; addr = a;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_type = 3'd0; bank_addr = 2'd0; addr = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1'b1; cmd_valid = 1'b0; cmd_type = 3'd0; bank_addr = 2'd0;
        addr = '0; bank_idle = 4'hF;
        idle(3);
        rst = 1'b0;
        idle(1);
    endtask

    task automatic t_reset;
        do_reset();
        chk_mode("R1 reset", 2, 0, 2, 0);
        chk("R1 reset busy", busy, 0);
        chk_errs("R1 reset", 0, 0, 0, 0);
    endtask

    task automatic t_program;
        do_reset();
        issue(3'd1, 2'd0, mr(3'b011, 1'b0, 3'b010));
        chk_mode("R2 cl3 seq bl4", 3, 0, 4, 0);
        idle(3);
        issue(3'd1, 2'd0, mr(3'b010, 1'b1, 3'b011));
        chk_mode("R2 cl2 intl bl8", 2, 1, 8, 0);
        idle(3);
        issue(3'd1, 2'd0, mr(3'b011, 1'b0, 3'b100));
        chk_mode("R2 cl3 seq bl16", 3, 0, 16, 0);
        idle(3);
        issue(3'd1, 2'd0, mr(3'b010, 1'b0, 3'b111));
        chk_mode("R2 full page", 2, 0, 0, 1);
        idle(3);
        issue(3'd1, 2'd0, mr(3'b011, 1'b1, 3'b001));
        chk_mode("R2 cl3 intl bl2", 3, 1, 2, 0);
        chk_errs("R2 no errors", 0, 0, 0, 0);
    endtask

    task automatic t_other_bank;
        do_reset();
        for (int b = 1; b < 4; b++) begin
            issue(3'd1, 2'(b), mr(3'b011, 1'b1, 3'b011));
            chk_mode("R3 nonzero bank", 2, 0, 2, 0);
            chk("R3 nonzero bank busy", busy, 0);
        end
        chk_errs("R3 nonzero bank", 0, 0, 0, 0);
    endtask

    task automatic t_reserved;
        do_reset();
        issue(3'd1, 2'd0, mr(3'b011, 1'b0, 3'b000));
        chk_mode("R4 bl code 000", 2, 0, 2, 0);
        chk("R4 bl code 000 flag", err_reserved, 1);
        chk("R4 no busy", busy, 0);
        do_reset();
        issue(3'd1, 2'd0, mr(3'b011, 1'b0, 3'b101));
        chk_mode("R4 bl code 101", 2, 0, 2, 0);
        chk("R4 bl code 101 flag", err_reserved, 1);
        do_reset();
        issue(3'd1, 2'd0, mr(3'b001, 1'b0, 3'b011));
        chk_mode("R4 cl code 001", 2, 0, 2, 0);
        chk("R4 cl code 001 flag", err_reserved, 1);
        do_reset();
        issue(3'd1, 2'd0, mr(3'b100, 1'b0, 3'b011));
        chk_mode("R4 cl code 100", 2, 0, 2, 0);
        chk("R4 cl code 100 flag", err_reserved, 1);
        do_reset();
        issue(3'd1, 2'd0, mr(3'b011, 1'b1, 3'b111));
        chk_mode("R4 full page interleaved", 2, 0, 2, 0);
        chk_errs("R4 full page interleaved", 0, 1, 0, 0);
    endtask

    task automatic t_not_idle;
        do_reset();
        bank_idle = 4'b1011;
        issue(3'd1, 2'd0, mr(3'b011, 1'b0, 3'b011));
        chk_mode("R5 bank open", 2, 0, 2, 0);
        chk("R5 bank open busy", busy, 0);
        chk_errs("R5 bank open", 1, 0, 0, 0);
        do_reset();
        bank_idle = 4'b0111;
        issue(3'd1, 2'd0, mr(3'b011, 1'b1, 3'b111));
        chk_errs("R5 priority over reserved", 1, 0, 0, 0);
        bank_idle = 4'hF;
    endtask

    task automatic t_busy;
        do_reset();
        issue(3'd1, 2'd0, mr(3'b011, 1'b0, 3'b011));
        chk("R6 busy cycle 1", busy, 1);
        idle(1);
        chk("R6 busy cycle 2", busy, 1);
        idle(1);
        chk("R6 busy released", busy, 0);
    endtask

    task automatic t_holdoff;
        do_reset();
        issue(3'd1, 2'd0, mr(3'b011, 1'b0, 3'b011));
        cmd_valid = 1'b1; cmd_type = 3'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R7 no-op in window", err_holdoff, 0);
        issue(3'd1, 2'd0, mr(3'b010, 1'b1, 3'b010));
        chk("R7 mode set in last busy cycle", err_holdoff, 1);
        chk_mode("R7 mode set ignored", 3, 0, 8, 0);
        do_reset();
        issue(3'd1, 2'd0, mr(3'b010, 1'b0, 3'b111));
        issue(3'd3, 2'd0, 13'h0400);
        chk_errs("R7 read in window", 0, 0, 1, 0);
    endtask

    task automatic t_fullpage_ap;
        do_reset();
        issue(3'd1, 2'd0, mr(3'b011, 1'b0, 3'b011));
        idle(2);
        issue(3'd3, 2'd1, 13'h0400);
        issue(3'd4, 2'd2, 13'h0400);
        chk("R8 bl8 with auto precharge", err_fullpage_ap, 0);
        issue(3'd1, 2'd0, mr(3'b011, 1'b0, 3'b111));
        idle(2);
        issue(3'd3, 2'd0, 13'h0010);
        chk("R8 full page read no ap", err_fullpage_ap, 0);
        issue(3'd4, 2'd0, 13'h0400);
        chk("R8 full page write ap", err_fullpage_ap, 1);
        do_reset();
        issue(3'd1, 2'd0, mr(3'b010, 1'b0, 3'b111));
        idle(2);
        issue(3'd3, 2'd3, 13'h0402);
        chk_errs("R8 full page read ap", 0, 0, 0, 1);
    endtask

    task automatic t_sticky;
        do_reset();
        issue(3'd1, 2'd0, mr(3'b000, 1'b0, 3'b001));
        issue(3'd1, 2'd0, mr(3'b011, 1'b1, 3'b100));
        idle(10);
        chk("R9 flag stays set", err_reserved, 1);
        chk_mode("R9 settings persist", 3, 1, 16, 0);
        issue(3'd2, 2'd0, 13'h0123);
        issue(3'd5, 2'd0, 13'h0400);
        chk_mode("R9 persist across commands", 3, 1, 16, 0);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        idle(1);
        chk("R9 reset clears flag", err_reserved, 0);
    endtask

    initial begin
        t_reset();
        t_program();
        t_other_bank();
        t_reserved();
        t_not_idle();
        t_busy();
        t_holdoff();
        t_fullpage_ap();
        t_sticky();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule